// File: doc/BRIEF.md
# Clock-Failure Monitor Control Register

This block holds the one-byte control word that configures a clock-failure monitor. Software writes the byte through a plain register port. The block sends three things to the monitor: an enable, a two-bit select that picks which clock to watch, and a forced-fail flag used for testing. It reads the byte back with the unused upper nibble fixed at zero. The clock-measurement detector sits outside this block, and its verdict arrives on a single input. The block combines that verdict with the test flag to produce one failure output.

Every register write is guarded by a short unlock window. The window opens only when a fixed key byte arrives on a separate protection port, and a write outside it has no effect. The monitor's interrupt-enable and interrupt-type settings come in as inputs. Once the monitor is enabled and both of those inputs are high, the enable and select fields freeze. They stay frozen until the next reset, even if the interrupt inputs drop later. The test flag can still be written while the fields are frozen.

Top module: `cfm_ctrl_reg`

## Requirements
- R1: After reset the readback byte is 0x00, all monitor outputs are low and `mon_src_valid` is high.
- R2: Writing the key 0x9E on the protection port opens a window. A register write is accepted on each of the next 4 clock edges after the key edge. A register write at any other time leaves the readback unchanged.
- R3: Any other value on the protection port does not open the window. Writing the key again while the window is open restarts the full 4-edge count.
- R4: Bit 0 of the byte is the monitor enable and drives `mon_enable`. Bits 3:2 are the clock select and drive `mon_src_sel`: 0 is the system clock, 1 is the fast external oscillator, 2 is the 32.768 kHz oscillator.
- R5: A select value of 3 is reserved. It is stored and read back as written, and `mon_src_valid` is low only while the stored select is 3.
- R6: An accepted write with bit 1 set raises `force_fail` and `fail_out`. An accepted write with bit 1 clear drops `force_fail`.
- R7: `fail_out` equals `force_fail` OR (`det_fail_in` AND enable). The detector input has no effect while the enable is 0.
- R8: While enable, `irq_fail_en` and `irq_type_nmi` are all 1, accepted writes leave bits 0 and 3:2 unchanged.
- R9: Once R8 has held for one clock edge, bits 0 and 3:2 stay frozen until reset, even after the interrupt inputs fall.
- R10: While the fields are frozen, an accepted write still updates bit 1.
- R11: Bits 7:4 ignore written values and always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| prot_wr_en | input | 1 | Protection port write strobe |
| prot_wr_data | input | 8 | Protection port data (key) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_data | output | 8 | Register readback |
| irq_fail_en | input | 1 | Monitor failure-interrupt enable setting |
| irq_type_nmi | input | 1 | Monitor interrupt-type setting |
| det_fail_in | input | 1 | Failure verdict from the external detector |
| mon_enable | output | 1 | Enable to the monitor |
| mon_src_sel | output | 2 | Monitored clock select |
| mon_src_valid | output | 1 | Low when the select is the reserved code |
| force_fail | output | 1 | Forced test failure |
| fail_out | output | 1 | Combined failure condition |

## Verification
The hardest situation to reach is the permanent freeze. To reach it, the bench must complete an unlocked write that sets the enable, raise both interrupt inputs, and then drop them again. Only after that can it check that a second unlocked write still cannot change the enable or the select, while the same write still changes the test bit. The directed task follows exactly that order. A separate task places writes on the last edge of the window and on the first edge after it, to pin down the window length.

// File: rtl/cfm_pkg.sv
package cfm_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SEL_W  = 2;

  typedef enum logic [1:0] {
    SRC_SYSCLK   = 2'd0,
    SRC_FAST_OSC = 2'd1,
    SRC_SLOW_OSC = 2'd2,
    SRC_RESERVED = 2'd3
  } cfm_src_e;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             tst;
    logic             en;
  } cfm_fields_t;

  localparam cfm_fields_t FIELDS_RST = '{sel: 2'd0, tst: 1'b0, en: 1'b0};

  // Next field value for an accepted write; frozen fields keep current value.
  function automatic cfm_fields_t cfm_apply_write(cfm_fields_t cur,
                                                 logic [3:0] wlow,
                                                 logic frozen);
    cfm_fields_t nxt;
    nxt.tst = wlow[1];
    nxt.en  = frozen ? cur.en  : wlow[0];
    nxt.sel = frozen ? cur.sel : wlow[3:2];
    return nxt;
  endfunction

  function automatic logic [BYTE_W-1:0] cfm_readback(cfm_fields_t f);
    return {4'b0000, f.sel, f.tst, f.en};
  endfunction

  function automatic logic cfm_fail_combine(logic tst, logic en, logic det);
    return tst | (det & en);
  endfunction

  function automatic logic cfm_src_ok(logic [SEL_W-1:0] sel);
    return sel != SRC_RESERVED;
  endfunction

endpackage

// File: rtl/cfm_unlock_window.sv
module cfm_unlock_window #(
  parameter int unsigned             DATA_W   = 8,
  parameter logic [DATA_W-1:0]       KEY      = 8'h9E,
  parameter int unsigned             WIN_LEN  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_wr_en,
  input  logic [DATA_W-1:0] prot_wr_data,
  output logic              win_open
);
  localparam int unsigned CNT_W = $clog2(WIN_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WIN_LEN);

  logic [CNT_W-1:0] cnt_q;
  logic             key_hit;

  assign key_hit  = prot_wr_en && (prot_wr_data == KEY);
  assign win_open = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (key_hit)  cnt_q <= CNT_LOAD;
    else if (win_open) cnt_q <= cnt_q - 1'b1;
  end

  // R2
  key_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit |=> win_open);

  // R3
  no_key_no_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!key_hit && !win_open) |=> !win_open);

  // R2
  win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LOAD);

endmodule

// File: rtl/cfm_lock_tracker.sv
module cfm_lock_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic en_q,
  input  logic irq_fail_en,
  input  logic irq_type_nmi,
  output logic lock_cond,
  output logic locked_q,
  output logic frozen
);
  assign lock_cond = en_q && irq_fail_en && irq_type_nmi;
  assign frozen    = locked_q || lock_cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         locked_q <= 1'b0;
    else if (lock_cond) locked_q <= 1'b1;
  end

  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> locked_q);

  // R9
  lock_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_cond |=> locked_q);

endmodule

// File: rtl/cfm_fail_path.sv
module cfm_fail_path
  import cfm_pkg::*;
(
  input  logic             tst,
  input  logic             en,
  input  logic             det_fail_in,
  input  logic [SEL_W-1:0] sel,
  output logic             force_fail,
  output logic             fail_out,
  output logic             src_valid
);
  assign force_fail = tst;
  assign fail_out   = cfm_fail_combine(tst, en, det_fail_in);
  assign src_valid  = cfm_src_ok(sel);

  // R7
  always_comb begin
    det_mask_chk: assert (!( !en && !tst && fail_out));
  end

endmodule

// File: rtl/cfm_ctrl_reg.sv
module cfm_ctrl_reg
  import cfm_pkg::*;
#(
  parameter logic [7:0]  UNLOCK_KEY = 8'h9E,
  parameter int unsigned UNLOCK_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prot_wr_en,
  input  logic [7:0] prot_wr_data,
  input  logic       reg_wr_en,
  input  logic [7:0] reg_wr_data,
  output logic [7:0] reg_rd_data,
  input  logic       irq_fail_en,
  input  logic       irq_type_nmi,
  input  logic       det_fail_in,
  output logic       mon_enable,
  output logic [1:0] mon_src_sel,
  output logic       mon_src_valid,
  output logic       force_fail,
  output logic       fail_out
);
  cfm_fields_t fields_q;
  logic        win_open;
  logic        wr_fire;
  logic        lock_cond;
  logic        locked_q;
  logic        frozen;
  logic [3:0]  wr_rsvd;

  assign wr_fire = reg_wr_en && win_open;
  assign wr_rsvd = reg_wr_data[7:4];

  cfm_unlock_window #(
    .DATA_W  (BYTE_W),
    .KEY     (UNLOCK_KEY),
    .WIN_LEN (UNLOCK_LEN)
  ) u_window (
    .clk          (clk),
    .rst_n        (rst_n),
    .prot_wr_en   (prot_wr_en),
    .prot_wr_data (prot_wr_data),
    .win_open     (win_open)
  );

  cfm_lock_tracker u_lock (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_q         (fields_q.en),
    .irq_fail_en  (irq_fail_en),
    .irq_type_nmi (irq_type_nmi),
    .lock_cond    (lock_cond),
    .locked_q     (locked_q),
    .frozen       (frozen)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fields_q <= FIELDS_RST;
    else if (wr_fire) fields_q <= cfm_apply_write(fields_q, reg_wr_data[3:0], frozen);
  end

  assign reg_rd_data = cfm_readback(fields_q);
  assign mon_enable  = fields_q.en;
  assign mon_src_sel = fields_q.sel;

  cfm_fail_path u_fail (
    .tst         (fields_q.tst),
    .en          (fields_q.en),
    .det_fail_in (det_fail_in),
    .sel         (fields_q.sel),
    .force_fail  (force_fail),
    .fail_out    (fail_out),
    .src_valid   (mon_src_valid)
  );

  // R2
  closed_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(reg_rd_data));

  // R8
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> ($stable(mon_enable) && $stable(mon_src_sel)));

  // R10
  frozen_tst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && frozen) |=> (force_fail == $past(reg_wr_data[1])));

  // R11
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && (wr_rsvd != 4'd0)) |=> (reg_rd_data[7:4] == 4'd0));

endmodule

// File: tb/test_cfm_ctrl_reg.sv
module test_cfm_ctrl_reg;
  localparam logic [7:0] KEY = 8'h9E;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prot_wr_en = 1'b0;
  logic [7:0] prot_wr_data = 8'h00;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wr_data = 8'h00;
  logic [7:0] reg_rd_data;
  logic       irq_fail_en = 1'b0;
  logic       irq_type_nmi = 1'b0;
  logic       det_fail_in = 1'b0;
  logic       mon_enable;
  logic [1:0] mon_src_sel;
  logic       mon_src_valid;
  logic       force_fail;
  logic       fail_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cfm_ctrl_reg i_cfm_ctrl_reg (
    .clk(clk), .rst_n(rst_n),
    .prot_wr_en(prot_wr_en), .prot_wr_data(prot_wr_data),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data),
    .irq_fail_en(irq_fail_en), .irq_type_nmi(irq_type_nmi),
    .det_fail_in(det_fail_in),
    .mon_enable(mon_enable), .mon_src_sel(mon_src_sel),
    .mon_src_valid(mon_src_valid), .force_fail(force_fail),
    .fail_out(fail_out)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    idle(2); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_prot(logic [7:0] d);
    prot_wr_en = 1'b1; prot_wr_data = d;
    @(negedge clk);
    prot_wr_en = 1'b0; prot_wr_data = 8'h00;
  endtask

  task automatic send_wr(logic [7:0] d);
    reg_wr_en = 1'b1; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wr_data = 8'h00;
  endtask

  task automatic unlocked_wr(logic [7:0] d);
    send_prot(KEY);
    send_wr(d);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 rd", reg_rd_data, 8'h00);
    chk("R1 outs", {3'b0, mon_enable, mon_src_sel, force_fail, fail_out}, 8'h00);
    chk("R1 valid", {7'b0, mon_src_valid}, 8'h01);
  endtask

  task automatic t_window();
    do_reset();
    send_wr(8'h05);
    chk("R2 no key", reg_rd_data, 8'h00);
    send_prot(KEY); idle(3);
    send_wr(8'h09);
    chk("R2 edge 4 accepted", reg_rd_data, 8'h09);
    send_prot(KEY); idle(4);
    send_wr(8'h04);
    chk("R2 edge 5 ignored", reg_rd_data, 8'h09);
  endtask

  task automatic t_key();
    do_reset();
    send_prot(8'h9F);
    send_wr(8'h01);
    chk("R3 wrong key", reg_rd_data, 8'h00);
    send_prot(KEY); idle(2);
    send_prot(KEY); idle(3);
    send_wr(8'h01);
    chk("R3 rekey reload", reg_rd_data, 8'h01);
  endtask

  task automatic t_fields();
    do_reset();
    unlocked_wr(8'h05);
    chk("R4 en/sel fast", {5'b0, mon_src_sel, mon_enable}, 8'h03);
    unlocked_wr(8'h09);
    chk("R4 sel slow", {6'b0, mon_src_sel}, 8'h02);
    chk("R5 valid for 2", {7'b0, mon_src_valid}, 8'h01);
    unlocked_wr(8'h0D);
    chk("R5 reserved stored", reg_rd_data, 8'h0D);
    chk("R5 reserved invalid", {7'b0, mon_src_valid}, 8'h00);
  endtask

  task automatic t_test_bit();
    do_reset();
    unlocked_wr(8'h02);
    chk("R6 force set", {6'b0, force_fail, fail_out}, 8'h03);
    unlocked_wr(8'h00);
    chk("R6 force clear", {6'b0, force_fail, fail_out}, 8'h00);
  endtask

  task automatic t_detector();
    do_reset();
    det_fail_in = 1'b1; idle(1);
    chk("R7 masked", {7'b0, fail_out}, 8'h00);
    unlocked_wr(8'h01);
    chk("R7 passes", {7'b0, fail_out}, 8'h01);
    det_fail_in = 1'b0; idle(1);
    chk("R7 clear", {7'b0, fail_out}, 8'h00);
  endtask

  task automatic t_lock();
    do_reset();
    unlocked_wr(8'h05);
    irq_fail_en = 1'b1; irq_type_nmi = 1'b1; idle(1);
    unlocked_wr(8'h08);
    chk("R8 frozen", reg_rd_data, 8'h05);
    irq_fail_en = 1'b0; irq_type_nmi = 1'b0; idle(1);
    unlocked_wr(8'h0A);
    chk("R9 sticky", {5'b0, mon_src_sel, mon_enable}, 8'h03);
    chk("R10 tst writable", reg_rd_data, 8'h07);
    unlocked_wr(8'hF5);
    chk("R11 upper zero", reg_rd_data, 8'h05);
    do_reset();
    unlocked_wr(8'h08);
    chk("R9 reset clears", reg_rd_data, 8'h08);
  endtask

  initial begin
    t_reset();
    t_window();
    t_key();
    t_fields();
    t_test_bit();
    t_detector();
    t_lock();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule